// File: doc/BRIEF.md
# Sequenced MixColumns Unit

This block applies the AES column-mixing transform to a 128-bit state. It has no combinational matrix multiplier. Instead it runs a fixed list of whole-register micro-operations, one per clock, over three 128-bit registers: the state register and two temporaries. The micro-operations are XOR, AND with a repeated byte mask followed by a shift, XOR with a shifted operand, and a one-byte rotation inside every 32-bit column. Doubling in GF(2^8) is done on all sixteen bytes in one pass, using masks and shifts. The mixing between bytes comes from the column rotations.

A host drives `state_in`, pulses `start` while the unit is idle, and waits for the one-cycle `done` pulse. It then reads `state_out`, which keeps the result until the next accepted start. Column c (0 to 3) occupies bits [127-32c : 96-32c]. Byte 0 of each column sits in the most significant byte of that 32-bit word.

Top module: `mixcol_seq`

## Requirements
- R1: After reset, `busy` and `done` are low and `state_out` is all zeros until the first start is accepted.
- R2: A `start` sampled high while `busy` is low loads `state_in` into the state register, and `busy` is high from the next cycle.
- R3: `done` is high for exactly one cycle, 13 clock edges after the edge that accepted `start`. `busy` falls on that same edge, and `done` is never high while `busy` is high.
- R4: For each column with input bytes a0..a3, where a0 is the most significant byte, output byte k equals 2·a(k) ⊕ 3·a(k+1) ⊕ a(k+2) ⊕ a(k+3), with indices taken mod 4 and products taken in GF(2^8) modulo x^8+x^4+x^3+x+1.
- R5: Doubling a byte with bit 7 set shifts it left and XORs 0x1B into the result (for example, 0x80 doubles to 0x1B and 0xFF doubles to 0xE5).
- R6: Each output column depends only on the same input column; bytes never move between columns.
- R7: A `start` that arrives while `busy` is high is ignored. It neither changes the running result nor delays `done`.
- R8: While the unit is idle and `start` is low, `state_out` holds its value.
- R9: A `start` given in the same cycle as `done` is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to load `state_in` and begin a transform |
| state_in | input | 128 | State to transform, column 0 in the top 32 bits |
| busy | output | 1 | Micro-operation sequence in progress |
| done | output | 1 | One-cycle pulse: result is valid on `state_out` |
| state_out | output | 128 | State register contents (the result after `done`) |

## Verification
`busy` rises one edge after an accepted start, and `done` and the result are due 13 edges after that start. The bench keeps a behavioural model that is advanced on every rising edge, with a queue of expected results. It compares `busy`, `done` and `state_out` on the falling edge of every cycle, so each output is read half a period after the edge that set it. Directed runs also count the falling edges between the start and `done`, and expect exactly 13. They cover a known column vector, bytes with the top bit set, column isolation, starts while busy and a back-to-back start in the `done` cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int COLS          = 4;
  localparam int BYTES_PER_COL = 4;
  localparam int BYTE_W        = 8;
  localparam int LANES         = COLS * BYTES_PER_COL;
  localparam int COL_W         = BYTES_PER_COL * BYTE_W;
  localparam int STATE_W       = LANES * BYTE_W;
  localparam int N_REGS        = 3;
  localparam int N_UOPS        = 13;
  localparam int STEP_W        = $clog2(N_UOPS);
  localparam int SHAMT_W       = 3;
  localparam logic [BYTE_W-1:0] HI_MASK = 8'h80;
  localparam logic [BYTE_W-1:0] LO_MASK = 8'h7F;

  typedef enum logic [1:0] {
    REG_ST = 2'd0,
    REG_T0 = 2'd1,
    REG_T1 = 2'd2
  } rsel_e;

  typedef enum logic [2:0] {
    U_ROT   = 3'd0,  // dst = per-column byte rotate of src_a
    U_XOR   = 3'd1,  // dst = src_a ^ src_b
    U_HIBIT = 3'd2,  // dst = (src_a & 80..80) >> 7
    U_LODBL = 3'd3,  // dst = (src_a & 7F..7F) << 1
    U_XSHL  = 3'd4   // dst = src_a ^ (src_b << sh)
  } ukind_e;

  typedef struct packed {
    ukind_e              kind;
    rsel_e               dst;
    rsel_e               src_a;
    rsel_e               src_b;
    logic [SHAMT_W-1:0]  sh;
  } uop_t;

  function automatic logic [STATE_W-1:0] lane_rep(input logic [BYTE_W-1:0] v);
    logic [STATE_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*BYTE_W +: BYTE_W] = v;
    return r;
  endfunction

  // top bit of every lane moved to bit 0 of the same lane
  function automatic logic [STATE_W-1:0] lane_hibit(input logic [STATE_W-1:0] w);
    return (w & lane_rep(HI_MASK)) >> (BYTE_W - 1);
  endfunction

  // lower seven bits of every lane shifted up, never crossing a lane
  function automatic logic [STATE_W-1:0] lane_lodbl(input logic [STATE_W-1:0] w);
    return (w & lane_rep(LO_MASK)) << 1;
  endfunction

  function automatic uop_t mk(input ukind_e k, input rsel_e d, input rsel_e a,
                              input rsel_e b, input int unsigned s);
    uop_t u;
    u.kind  = k;
    u.dst   = d;
    u.src_a = a;
    u.src_b = b;
    u.sh    = SHAMT_W'(s);
    return u;
  endfunction

  // S holds the input s; final S = 2(s^r1) ^ r1 ^ r2 ^ r3
  function automatic uop_t uop_rom(input int unsigned idx);
    case (idx)
      0:       return mk(U_ROT,   REG_T0, REG_ST, REG_ST, 0); // T0 = r1
      1:       return mk(U_XOR,   REG_T1, REG_ST, REG_T0, 0); // T1 = s^r1
      2:       return mk(U_ROT,   REG_ST, REG_T0, REG_T0, 0); // S  = r2
      3:       return mk(U_XOR,   REG_T0, REG_T0, REG_ST, 0); // T0 = r1^r2
      4:       return mk(U_ROT,   REG_ST, REG_ST, REG_ST, 0); // S  = r3
      5:       return mk(U_XOR,   REG_T0, REG_T0, REG_ST, 0); // T0 = r1^r2^r3
      6:       return mk(U_HIBIT, REG_ST, REG_T1, REG_T1, 0); // S  = H
      7:       return mk(U_LODBL, REG_T1, REG_T1, REG_T1, 0); // T1 = low<<1
      8:       return mk(U_XSHL,  REG_T1, REG_T1, REG_ST, 0); // ^H
      9:       return mk(U_XSHL,  REG_T1, REG_T1, REG_ST, 1); // ^H<<1
      10:      return mk(U_XSHL,  REG_T1, REG_T1, REG_ST, 3); // ^H<<3
      11:      return mk(U_XSHL,  REG_T1, REG_T1, REG_ST, 4); // ^H<<4
      default: return mk(U_XOR,   REG_ST, REG_T0, REG_T1, 0); // S = result
    endcase
  endfunction
endpackage

// File: rtl/mcs_regfile.sv
module mcs_regfile
  import mcs_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [STATE_W-1:0]             load_data,
  input  logic                           we,
  input  rsel_e                          wsel,
  input  logic [STATE_W-1:0]             wdata,
  output logic [N_REGS-1:0][STATE_W-1:0] regs
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic [STATE_W-1:0] q;
    logic               hit;
    assign hit = we && (2'(wsel) == 2'(g));
    if (g == int'(REG_ST)) begin : g_state
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (load) q <= load_data;
        else if (hit)  q <= wdata;
      end
    end else begin : g_temp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit)  q <= wdata;
      end
    end
    assign regs[g] = q;
  end
endmodule

// File: rtl/mcs_alu.sv
module mcs_alu
  import mcs_pkg::*;
(
  input  uop_t                           uop,
  input  logic [N_REGS-1:0][STATE_W-1:0] regs,
  output logic [STATE_W-1:0]             result
);
  logic [STATE_W-1:0] opa, opb, rot;

  assign opa = regs[uop.src_a];
  assign opb = regs[uop.src_b];

  // one byte toward the column's most significant end, per column
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [COL_W-1:0] w;
    assign w = opa[c*COL_W +: COL_W];
    assign rot[c*COL_W +: COL_W] = {w[COL_W-BYTE_W-1:0], w[COL_W-1 -: BYTE_W]};
  end

  always_comb begin
    case (uop.kind)
      U_ROT:   result = rot;
      U_XOR:   result = opa ^ opb;
      U_HIBIT: result = lane_hibit(opa);
      U_LODBL: result = lane_lodbl(opa);
      U_XSHL:  result = opa ^ (opb << uop.sh);
      default: result = opa;
    endcase
  end
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output uop_t uop,
  output logic load_evt,
  output logic op_fire,
  output logic last_op
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_UOPS - 1);

  logic [STEP_W-1:0] step;

  assign load_evt = start && !busy;
  assign op_fire  = busy;
  assign last_op  = busy && (step == LAST);
  assign uop      = uop_rom(32'(step));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
    end else begin
      done <= 1'b0;
      if (load_evt) begin
        busy <= 1'b1;
        step <= '0;
      end else if (last_op) begin
        busy <= 1'b0;
        done <= 1'b1;
        step <= '0;
      end else if (op_fire) begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mixcol_seq.sv
module mixcol_seq
  import mcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [127:0]       state_in,
  output logic               busy,
  output logic               done,
  output logic [127:0]       state_out
);
  uop_t                           uop;
  logic                           load_evt;
  logic                           op_fire;
  logic                           last_op;
  logic [N_REGS-1:0][STATE_W-1:0] regs;
  logic [STATE_W-1:0]             alu_res;

  mcs_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .uop      (uop),
    .load_evt (load_evt),
    .op_fire  (op_fire),
    .last_op  (last_op)
  );

  mcs_alu u_alu (
    .uop    (uop),
    .regs   (regs),
    .result (alu_res)
  );

  mcs_regfile u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .load_data (state_in),
    .we        (op_fire),
    .wsel      (uop.dst),
    .wdata     (alu_res),
    .regs      (regs)
  );

  assign state_out = regs[REG_ST];
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] state_out,
  input logic         load_evt,
  input logic         op_fire,
  input logic         last_op
);
  p_load_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> busy);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_op |=> (done && !busy));

  p_no_done_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> (!load_evt && op_fire));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(state_out));

  p_accept_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |-> load_evt);
endmodule

bind mixcol_seq mcs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .state_out (state_out),
  .load_evt  (load_evt),
  .op_fire   (op_fire),
  .last_op   (last_op)
);

// File: tb/mixcol_seq_test.sv
`timescale 1ns/1ps
module mixcol_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] state_in = '0;
  logic         busy, done;
  logic [127:0] state_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  mixcol_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
    .busy(busy), .done(done), .state_out(state_out)
  );

  function automatic logic [7:0] dbl(input logic [7:0] v);
    int t;
    t = int'(v) * 2;
    if (t > 255) t = (t - 256) ^ 27;
    return 8'(t);
  endfunction

  function automatic logic [127:0] mixref(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0]   a [4];
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 4; i++) a[i] = s[127 - 32*c - 8*i -: 8];
      for (int k = 0; k < 4; k++)
        o[127 - 32*c - 8*k -: 8] = dbl(a[k]) ^ dbl(a[(k+1)%4]) ^ a[(k+1)%4]
                                   ^ a[(k+2)%4] ^ a[(k+3)%4];
    end
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural cycle model
  logic [127:0] pend [$];
  bit           m_busy = 0, m_done = 0, m_loaded = 0;
  int           m_cnt = 0;
  logic [127:0] m_out = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_loaded <= 0; m_cnt <= 0; m_out <= '0;
      pend.delete();
    end else begin
      m_done <= 0;
      if (m_busy) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          m_busy <= 0;
          m_done <= 1;
          m_out  <= pend.pop_front();
        end
      end else if (start) begin
        m_busy   <= 1;
        m_cnt    <= 13;
        m_loaded <= 1;
        pend.push_back(mixref(state_in));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R2 busy vs model", 128'(busy), 128'(m_busy));
      chk(done == m_done, "R3 done vs model", 128'(done), 128'(m_done));
      if (!m_loaded)
        chk(state_out == '0, "R1 state_out before first start", state_out, '0);
      else if (m_done)
        chk(state_out === m_out, "R4 result at done", state_out, m_out);
      else if (!m_busy)
        chk(state_out === m_out, "R8 result held while idle", state_out, m_out);
    end
  end

  task automatic launch(input logic [127:0] d);
    @(negedge clk);
    state_in = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [127:0] x, y, r1, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && state_out == '0, "R1 reset state",
        {busy, done, state_out[125:0]}, '0);

    // R4 known column vector
    launch({32'hdb135345, 32'hf20a225c, 32'h01010101, 32'hc6c6c6c6});
    chk(busy, "R2 busy after accepted start", 128'(busy), 128'd1);
    wait_done(cyc);
    chk(cyc == 13, "R3 latency to done", 128'(cyc), 128'd13);
    chk(state_out == {32'h8e4da1bc, 32'h9fdc589d, 32'h01010101, 32'hc6c6c6c6},
        "R4 known column vector", state_out,
        {32'h8e4da1bc, 32'h9fdc589d, 32'h01010101, 32'hc6c6c6c6});
    @(negedge clk);
    chk(!done, "R3 done lasts one cycle", 128'(done), 128'd0);

    // R5 reduction on bytes with top bit set
    launch({32'h80000000, 32'hff000000, 32'h00000000, 32'h01000000});
    wait_done(cyc);
    chk(state_out == {32'h1b80809b, 32'he5ffff1a, 32'h00000000, 32'h02010103},
        "R5 top-bit doubling", state_out,
        {32'h1b80809b, 32'he5ffff1a, 32'h00000000, 32'h02010103});

    // R6 column isolation: alter only column 2
    x = 128'h0123456789abcdef_fedcba9876543210;
    launch(x);
    wait_done(cyc);
    r1 = state_out;
    y = x;
    y[63:32] = 32'h5a5aa5a5;
    launch(y);
    wait_done(cyc);
    r2 = state_out;
    chk({r1[127:64], r1[31:0]} == {r2[127:64], r2[31:0]},
        "R6 other columns unchanged", r2, r1);
    chk(r2 == mixref(y), "R6 altered column result", r2, mixref(y));

    // R7 start while busy is ignored
    x = 128'hd4bf5d30e0b452aeb84111f11e2798e5;
    launch(x);
    repeat (3) @(negedge clk);
    state_in = 128'hffffffff_00000000_12345678_9abcdef0;
    start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk(cyc == 13 - 5, "R7 done not delayed", 128'(cyc), 128'd8);
    chk(state_out == mixref(x), "R7 result of first state", state_out, mixref(x));

    // R8 hold while idle
    r1 = state_out;
    repeat (6) @(negedge clk);
    chk(state_out == r1 && !busy, "R8 held over idle cycles", state_out, r1);

    // R9 back-to-back start in the done cycle
    launch(128'h11223344_55667788_99aabbcc_ddeeff00);
    wait_done(cyc);
    y = 128'hc0ffee00_deadbeef_00ff00ff_80808080;
    state_in = y;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9 start in done cycle accepted", 128'(busy), 128'd1);
    wait_done(cyc);
    chk(cyc == 13, "R9 back-to-back latency", 128'(cyc), 128'd13);
    chk(state_out == mixref(y), "R9 back-to-back result", state_out, mixref(y));

    // R4 random states
    for (int n = 0; n < 20; n++) begin
      x = {$urandom, $urandom, $urandom, $urandom};
      launch(x);
      wait_done(cyc);
      chk(state_out == mixref(x), "R4 random state", state_out, mixref(x));
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule